// File: doc/BRIEF.md
# Binary Point Priority Splitter

This block holds the binary point of one virtual interrupt group and uses it to divide an 8-bit interrupt priority into two parts. The upper part is the group priority, which alone decides whether one interrupt may preempt another. The lower part is the subpriority, which only orders interrupts inside a group. A binary point of N keeps priority bits [7:N] as the group priority and treats bits [N-1:0] as the subpriority. The group priority is formed by clearing those low bits.

Software reaches the binary point through a 32-bit register. Only the low three bits carry state. A write below a configured floor is raised to the floor, and this includes a write of zero. A common-binary-point control input can place the register under the companion group. While that input is high, the register reads as the companion group's binary point plus one, capped at 7. That value also drives the split, and software writes are dropped. The block outputs the masked group priority of any priority presented to it. It also gives a combinational preemption decision between an incoming priority and the running priority.

Top module: `bpt_prio_split`

## Requirements
- R1: After reset, with common_bp low, rd_data reads the parameter FLOOR (default 1), and bits [31:3] read as zero.
- R2: A write with common_bp low and wr_data[2:0] >= FLOOR stores wr_data[2:0]. Bits [31:3] of the write are discarded, and rd_data[31:3] is always zero.
- R3: A write with common_bp low and wr_data[2:0] < FLOOR stores FLOOR. With the default FLOOR of 1, this means a write of 0 reads back as 1.
- R4: grp_prio_out equals prio_in with bits [N-1:0] forced to zero, where N is the effective binary point reported in rd_data[2:0].
- R5: While common_bp is high, rd_data[2:0] equals peer_bp + 1, or 7 when peer_bp is 7.
- R6: While common_bp is high, writes leave the stored value unchanged. When common_bp returns low, the value stored before reads back. Whether a write is taken is decided by common_bp in the same clock cycle as wr_en.
- R7: preempt is 1 exactly when the group priority of incoming_prio is numerically lower than that of running_prio. Priorities whose group parts are equal never preempt, even when their subpriorities differ.
- R8: While common_bp is high, the split for grp_prio_out and preempt uses the companion-derived value from R5, not the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value (effective binary point in [2:0]) |
| common_bp | input | 1 | Common binary point control |
| peer_bp | input | 3 | Binary point of the companion group |
| prio_in | input | 8 | Priority to split |
| grp_prio_out | output | 8 | Group priority of prio_in, subpriority bits cleared |
| incoming_prio | input | 8 | Priority of the candidate interrupt |
| running_prio | input | 8 | Priority currently running |
| preempt | output | 1 | Candidate's group priority is strictly higher (lower value) |

## Verification
A register write and a change of the common-binary-point control can fall in the same clock edge. The outcome depends only on the control level sampled at that edge. The bench raises wr_en and lowers common_bp on the same negative edge and expects the write to land. In a second case it raises wr_en and common_bp together and expects the old value to survive once the control drops. Each case is judged by reading rd_data after the edge with the control low.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

   // Source that feeds the effective binary point
   typedef enum logic {
      BP_SRC_OWN  = 1'b0,
      BP_SRC_PEER = 1'b1
   } bp_src_e;

   // Saturating increment for a binary point of any width
   function automatic logic [7:0] sat_inc8(input logic [7:0] v, input logic [7:0] max_v);
      return (v >= max_v) ? max_v : v + 8'd1;
   endfunction

endpackage

// File: rtl/bpt_reg.sv
module bpt_reg
   import bpt_pkg::*;
#(
   parameter int BP_W  = 3,
   parameter int REG_W = 32,
   parameter int FLOOR = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             common_bp,
   input  logic [BP_W-1:0]  peer_bp,
   output logic [BP_W-1:0]  bp_q,
   output logic [BP_W-1:0]  eff_bp,
   output logic [REG_W-1:0] rd_data
);

   localparam int           BP_MAX_I = (1 << BP_W) - 1;
   localparam logic [7:0]   BP_MAX8  = 8'(BP_MAX_I);
   localparam [BP_W-1:0]    FLOOR_V  = BP_W'(FLOOR);

   if (FLOOR < 1 || FLOOR > BP_MAX_I) begin : g_bad_floor
      $error("bpt_reg: FLOOR out of range");
   end
   if (REG_W <= BP_W) begin : g_bad_regw
      $error("bpt_reg: REG_W must exceed BP_W");
   end
   if (BP_W > 8) begin : g_bad_bpw
      $error("bpt_reg: BP_W too wide");
   end

   bp_src_e         src;
   logic [BP_W-1:0] wr_val;
   logic [BP_W-1:0] wr_next;
   logic [BP_W-1:0] peer_inc;
   logic            unused_hi;

   assign unused_hi = ^wr_data[REG_W-1:BP_W];
   assign wr_val    = wr_data[BP_W-1:0];
   assign wr_next   = (wr_val < FLOOR_V) ? FLOOR_V : wr_val;

   always_comb begin
      peer_inc = BP_W'(sat_inc8(8'(peer_bp), BP_MAX8));
   end

   assign src = common_bp ? BP_SRC_PEER : BP_SRC_OWN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_q <= FLOOR_V;
      end else if (wr_en && (src == BP_SRC_OWN)) begin
         bp_q <= wr_next;
      end
   end

   always_comb begin
      unique case (src)
         BP_SRC_PEER: eff_bp = peer_inc;
         default:     eff_bp = bp_q;
      endcase
   end

   assign rd_data = {{(REG_W-BP_W){1'b0}}, eff_bp};

endmodule

// File: rtl/bpt_mask.sv
module bpt_mask #(
   parameter int PRIO_W = 8,
   parameter int BP_W   = 3
) (
   input  logic [BP_W-1:0]   eff_bp,
   input  logic [PRIO_W-1:0] prio,
   output logic [PRIO_W-1:0] grp
);

   logic [PRIO_W-1:0] keep;

   for (genvar i = 0; i < PRIO_W; i++) begin : g_bit
      assign keep[i] = (32'(i) >= 32'(eff_bp));
      assign grp[i]  = prio[i] & keep[i];
   end

endmodule

// File: rtl/bpt_preempt.sv
module bpt_preempt #(
   parameter int PRIO_W = 8
) (
   input  logic [PRIO_W-1:0] grp_incoming,
   input  logic [PRIO_W-1:0] grp_running,
   output logic              preempt
);

   assign preempt = (grp_incoming < grp_running);

endmodule

// File: rtl/bpt_prio_split.sv
module bpt_prio_split #(
   parameter int PRIO_W = 8,
   parameter int REG_W  = 32,
   parameter int FLOOR  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic              common_bp,
   input  logic [2:0]        peer_bp,
   input  logic [PRIO_W-1:0] prio_in,
   output logic [PRIO_W-1:0] grp_prio_out,
   input  logic [PRIO_W-1:0] incoming_prio,
   input  logic [PRIO_W-1:0] running_prio,
   output logic              preempt
);

   localparam int BP_W = 3;

   if (PRIO_W < (1 << BP_W)) begin : g_bad_prio
      $error("bpt_prio_split: PRIO_W too small for binary point range");
   end

   logic [BP_W-1:0]   bp_q;
   logic [BP_W-1:0]   eff_bp;
   logic [PRIO_W-1:0] grp_inc;
   logic [PRIO_W-1:0] grp_run;

   bpt_reg #(.BP_W(BP_W), .REG_W(REG_W), .FLOOR(FLOOR)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .common_bp (common_bp),
      .peer_bp   (peer_bp),
      .bp_q      (bp_q),
      .eff_bp    (eff_bp),
      .rd_data   (rd_data)
   );

   bpt_mask #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_mask_out (
      .eff_bp (eff_bp),
      .prio   (prio_in),
      .grp    (grp_prio_out)
   );

   bpt_mask #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_mask_inc (
      .eff_bp (eff_bp),
      .prio   (incoming_prio),
      .grp    (grp_inc)
   );

   bpt_mask #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_mask_run (
      .eff_bp (eff_bp),
      .prio   (running_prio),
      .grp    (grp_run)
   );

   bpt_preempt #(.PRIO_W(PRIO_W)) u_cmp (
      .grp_incoming (grp_inc),
      .grp_running  (grp_run),
      .preempt      (preempt)
   );

endmodule

// File: rtl/bpt_prio_split_chk.sv
module bpt_prio_split_chk #(
   parameter int PRIO_W = 8,
   parameter int REG_W  = 32,
   parameter int FLOOR  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_W-1:0]  wr_data,
   input logic [REG_W-1:0]  rd_data,
   input logic              common_bp,
   input logic [2:0]        peer_bp,
   input logic [PRIO_W-1:0] prio_in,
   input logic [PRIO_W-1:0] grp_prio_out,
   input logic [PRIO_W-1:0] incoming_prio,
   input logic [PRIO_W-1:0] running_prio,
   input logic              preempt,
   input logic [2:0]        bp_q
);

   logic [2:0] eff_w;
   assign eff_w = rd_data[2:0];

   // R1
   reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_n) && !common_bp) |-> (rd_data[2:0] == 3'(FLOOR)));

   // R2
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-1:3] == '0);

   // R2
   store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !common_bp && wr_data[2:0] >= 3'(FLOOR)) ##1 !common_bp
      |-> rd_data[2:0] == $past(wr_data[2:0]));

   // R3
   clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !common_bp && wr_data[2:0] < 3'(FLOOR)) ##1 !common_bp
      |-> rd_data[2:0] == 3'(FLOOR));

   // R5
   sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      common_bp |-> rd_data[2:0] == ((peer_bp == 3'd7) ? 3'd7 : peer_bp + 3'd1));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      common_bp |=> $stable(bp_q));

   // R4
   grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grp_prio_out >> eff_w) == (prio_in >> eff_w)) &&
      ((grp_prio_out & ~({PRIO_W{1'b1}} << eff_w)) == '0));

   // R7
   preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preempt == ((incoming_prio >> eff_w) < (running_prio >> eff_w)));

endmodule

bind bpt_prio_split bpt_prio_split_chk #(
   .PRIO_W (PRIO_W),
   .REG_W  (REG_W),
   .FLOOR  (FLOOR)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .rd_data       (rd_data),
   .common_bp     (common_bp),
   .peer_bp       (peer_bp),
   .prio_in       (prio_in),
   .grp_prio_out  (grp_prio_out),
   .incoming_prio (incoming_prio),
   .running_prio  (running_prio),
   .preempt       (preempt),
   .bp_q          (bp_q)
);

// File: tb/bpt_prio_split_bench.sv
module bpt_prio_split_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        common_bp = 1'b0;
   logic [2:0]  peer_bp = '0;
   logic [7:0]  prio_in = '0;
   logic [7:0]  grp_prio_out;
   logic [7:0]  incoming_prio = '0;
   logic [7:0]  running_prio = '0;
   logic        preempt;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bpt_prio_split u_bpt_prio_split (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .rd_data       (rd_data),
      .common_bp     (common_bp),
      .peer_bp       (peer_bp),
      .prio_in       (prio_in),
      .grp_prio_out  (grp_prio_out),
      .incoming_prio (incoming_prio),
      .running_prio  (running_prio),
      .preempt       (preempt)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_eq(input string req, input longint act, input longint exp);
      check(act == exp, req, act, exp);
   endtask

   task automatic do_write(input logic [31:0] v, input logic cbp);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      common_bp = cbp;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   function automatic int grp_of(input int p, input int n);
      return (p >> n) << n;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset value and zero upper bits
      check_eq("R1", rd_data, 32'd1);

      // R2 legal write, upper write bits dropped
      do_write(32'hFFFF_FFF5, 1'b0);
      check_eq("R2", rd_data, 32'd5);

      // R3 write of zero and of a value whose low field is zero
      do_write(32'h0, 1'b0);
      check_eq("R3", rd_data, 32'd1);
      do_write(32'h8, 1'b0);
      check_eq("R3", rd_data, 32'd1);

      // R4 and R7 sweeps per binary point
      for (int n = 1; n < 8; n++) begin
         do_write(32'(n), 1'b0);
         check_eq("R2", rd_data, n);
         for (int p = 0; p < 256; p++) begin
            prio_in = 8'(p);
            #1;
            check_eq("R4", grp_prio_out, grp_of(p, n));
         end
         for (int a = 0; a < 256; a += 7) begin
            for (int b = 0; b < 256; b += 11) begin
               incoming_prio = 8'(a);
               running_prio = 8'(b);
               #1;
               check_eq("R7", preempt, ((a >> n) < (b >> n)) ? 1 : 0);
            end
         end
         // R7 same group, lower subpriority value: no preemption
         incoming_prio = 8'h40;
         running_prio  = 8'(8'h40 | ((1 << n) - 1));
         #1;
         check_eq("R7", preempt, 0);
         // R7 one group step apart preempts
         incoming_prio = 8'h40;
         running_prio  = 8'(8'h40 + (1 << n));
         #1;
         check_eq("R7", preempt, 1);
      end

      // R5 and R8 common mode over every companion value
      do_write(32'd4, 1'b0);
      @(negedge clk);
      common_bp = 1'b1;
      for (int q = 0; q < 8; q++) begin
         int e;
         e = (q == 7) ? 7 : q + 1;
         peer_bp = 3'(q);
         prio_in = 8'hFF;
         #1;
         check_eq("R5", rd_data, e);
         check_eq("R8", grp_prio_out, grp_of(255, e));
         incoming_prio = 8'h00;
         running_prio  = 8'(((1 << e) - 1));
         #1;
         check_eq("R8", preempt, 0);
      end

      // R6 write ignored in common mode
      peer_bp = 3'd1;
      do_write(32'd6, 1'b1);
      @(negedge clk);
      common_bp = 1'b0;
      #1;
      check_eq("R6", rd_data, 32'd4);

      // R6 write and control drop in the same cycle: write lands
      @(negedge clk);
      common_bp = 1'b1;
      do_write(32'd3, 1'b0);
      check_eq("R6", rd_data, 32'd3);

      // R6 write and control rise in the same cycle: write dropped
      do_write(32'd7, 1'b1);
      check_eq("R6", rd_data, 32'd2);
      @(negedge clk);
      common_bp = 1'b0;
      #1;
      check_eq("R6", rd_data, 32'd3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule